// File: doc/BRIEF.md
# Display Controller I2C Slave Front End

This block is the serial front end of a small display controller. It watches the two I2C lines through synchronisers and detects START, repeated START and STOP. It claims a 7-bit slave address whose upper six bits are a parameter and whose lowest bit comes from a strap pin. It then acknowledges every byte it accepts by pulling SDA low through an open-drain enable.

After the address of a write, the bytes form pairs: a control byte, then one payload byte. The control byte carries a continuation flag and a data/command flag. While the continuation flag is set, the pairs keep coming. The first control byte with the flag cleared turns the rest of the transfer into a plain stream of payload bytes. A payload byte goes to one of two places. In command mode it appears as a one-cycle command strobe for the decoder outside this block. In data mode it becomes a write into display RAM at an internal pointer, and the pointer steps forward after each write.

When the address carries the read flag, the block sends bytes to the master. The kind of byte depends on the data/command flag kept from the most recent write: display RAM contents at the pointer, or an external status byte. Sending stops as soon as the master leaves a byte unacknowledged.

Top module: `panel_i2c_slave`

## Requirements
- R1: While reset is held, and on the first cycle after it, `sda_oe` is 0, `ram_we` and `cmd_valid` are 0, and `ram_raddr` is 0.
- R2: The block's address is `{ADDR_HI, addr_lsb}`, sent as the upper 7 bits of the first byte after START. The R/W flag is bit 0 of that byte, where 0 means write. On a match, the block pulls SDA low during the ninth clock of that byte.
- R3: If the address does not match, the block acknowledges nothing and emits no strobe for any byte until the next START.
- R4: A control byte with bit 7 (continuation) set is followed by exactly one payload byte. The byte after that is parsed as a control byte again and produces no strobe itself.
- R5: After a control byte with bit 7 clear, every later byte up to STOP is payload, whatever its value.
- R6: In data mode (control bit 6 = 1), a payload byte pulses `ram_we` for one cycle, with `ram_waddr` equal to the pointer and `ram_wdata` equal to the byte. The pointer then increments modulo 2^AW.
- R7: In command mode (control bit 6 = 0), a payload byte pulses `cmd_valid` for one cycle with `cmd_byte` equal to the byte. `ram_we` is never high in the same cycle.
- R8: Once addressed for a write, the block acknowledges every control byte and every payload byte. Its SDA drive changes only while SCL is low.
- R9: STOP ends the transfer. After a new START and a matching address, the first byte is parsed as a control byte again.
- R10: On a read, the block drives the first byte right after its address acknowledge. If the last write's control bit 6 was 1, each byte is `ram_rdata` at the pointer and the pointer advances once per byte sent. If it was 0, each byte is `stat_i` and the pointer does not move.
- R11: When the master does not acknowledge a read byte, the block releases SDA and drives nothing more until the next START.
- R12: A repeated START, with no STOP before it, restarts address matching, even after a mismatched address.
- R13: A one-cycle `ptr_ld` sets the pointer to `ptr_val` and takes priority over an increment in the same cycle. `ram_raddr` always shows the pointer.
- R14: Bits 5 to 0 of a control byte have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_lsb | input | 1 | Strap for the lowest address bit |
| ptr_ld | input | 1 | Load the RAM pointer |
| ptr_val | input | AW | Pointer value for `ptr_ld` |
| stat_i | input | 8 | Status byte returned by reads in command mode |
| ram_rdata | input | 8 | RAM read data at `ram_raddr` (combinational read) |
| ram_raddr | output | AW | Current RAM pointer |
| ram_we | output | 1 | RAM write strobe |
| ram_waddr | output | AW | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| cmd_valid | output | 1 | Command byte strobe |
| cmd_byte | output | 8 | Command byte |

## Verification
The bench builds the block with AW = 4, which gives a 16-entry pointer space, so a pointer load near the top followed by three writes reaches the wrap-around to zero within one short transfer. ADDR_HI and SYNC_STAGES keep their defaults, and the strap is tied to 1, so an address ending in 0 is a ready-made mismatch. A 16-cycle SCL half period leaves room for the synchroniser delay. Under that margin the bench can also test that the drive changes only while SCL is low.

// File: rtl/i2cd_pkg.sv
// Shared definitions for the display I2C front end.
// Assumes: control byte layout with continuation at bit 7, data/command at bit 6.
package i2cd_pkg;
    localparam int CO_BIT = 7;
    localparam int DC_BIT = 6;

    typedef enum logic [2:0] {
        PS_IDLE,    // not addressed, ignore bytes until START
        PS_ADDR,    // next byte is the slave address
        PS_CTRL,    // next byte is a control byte
        PS_PAIR,    // next byte is a single payload byte, then control
        PS_STREAM,  // all remaining bytes are payload
        PS_READ     // slave is transmitting
    } pstate_t;
endpackage

// File: rtl/i2cd_sync.sv
// Multi-flop synchroniser for one asynchronous line.
// Assumes: STAGES >= 2; idle level of the line is high.
module i2cd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) ff <= '1;
        else        ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/i2cd_line_mon.sv
// Synchronises SCL and SDA and derives clock edges and START/STOP events.
// Assumes: SCL and SDA stay stable for more than STAGES+1 clk cycles each phase.
module i2cd_line_mon #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_s
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] syn;
    logic              scl_q;
    logic              sda_q;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2cd_sync #(.STAGES(STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw[g]),
            .q     (syn[g])
        );
    end

    // Keep the previous synchronised level of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= syn[0];
            sda_q <= syn[1];
        end
    end

    assign sda_s     = syn[1];
    assign scl_rise  =  syn[0] & ~scl_q;
    assign scl_fall  = ~syn[0] &  scl_q;
    assign start_det =  syn[0] &  scl_q &  sda_q & ~syn[1];
    assign stop_det  =  syn[0] &  scl_q & ~sda_q &  syn[1];
endmodule

// File: rtl/i2cd_link.sv
// Bit-level engine: shifts bytes in, drives acknowledge and read bits out.
// Assumes: ack_go is settled before the SCL fall that opens the ninth bit;
// tx_byte is valid in the cycle tx_load is raised.
module i2cd_link (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       sda_s,
    input  logic       ack_go,
    input  logic       rd_on,
    input  logic [7:0] tx_byte,
    output logic       byte_rdy,
    output logic [7:0] rx_byte,
    output logic       tx_load,
    output logic       sda_oe
);
    localparam logic [3:0] LAST_BIT = 4'd7;
    localparam logic [3:0] ACK_SLOT = 4'd8;
    localparam logic [3:0] ACK_DONE = 4'd9;

    logic [3:0] bcnt;
    logic [7:0] shreg;
    logic [7:0] txsh;
    logic       drv;
    logic       tx_act;
    logic       cont;
    logic       halt;

    // Bit counter, receive shift, ninth-bit sampling and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt     <= '0;
            shreg    <= '0;
            txsh     <= '1;
            drv      <= 1'b0;
            tx_act   <= 1'b0;
            cont     <= 1'b0;
            halt     <= 1'b0;
            byte_rdy <= 1'b0;
            tx_load  <= 1'b0;
        end else begin
            byte_rdy <= 1'b0;
            tx_load  <= 1'b0;
            if (start_det || stop_det) begin
                bcnt   <= '0;
                drv    <= 1'b0;
                tx_act <= 1'b0;
                halt   <= 1'b0;
            end else if (scl_rise) begin
                if (bcnt < ACK_SLOT) begin
                    shreg <= {shreg[6:0], sda_s};
                    bcnt  <= bcnt + 4'd1;
                    if (bcnt == LAST_BIT) byte_rdy <= 1'b1;
                end else if (bcnt == ACK_SLOT) begin
                    cont <= ~sda_s;
                    bcnt <= ACK_DONE;
                end
            end else if (scl_fall) begin
                if (bcnt == ACK_SLOT) begin
                    drv <= tx_act ? 1'b0 : ack_go;
                end else if (bcnt == ACK_DONE) begin
                    bcnt <= '0;
                    if (rd_on && cont && !halt) begin
                        txsh    <= tx_byte;
                        drv     <= ~tx_byte[7];
                        tx_act  <= 1'b1;
                        tx_load <= 1'b1;
                    end else begin
                        drv <= 1'b0;
                        if (tx_act) halt <= 1'b1;
                        tx_act <= 1'b0;
                    end
                end else if (tx_act && bcnt != 4'd0) begin
                    txsh <= {txsh[6:0], 1'b1};
                    drv  <= ~txsh[6];
                end
            end
        end
    end

    assign rx_byte = shreg;
    assign sda_oe  = drv;
endmodule

// File: rtl/i2cd_frame.sv
// Byte-level parser: address match, control/payload pairing, output steering.
// Assumes: byte_rdy pulses once per received byte with rx_byte valid.
module i2cd_frame
    import i2cd_pkg::*;
#(
    parameter int         AW      = 10,
    parameter logic [5:0] ADDR_HI = 6'b011110
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          byte_rdy,
    input  logic [7:0]    rx_byte,
    input  logic          tx_load,
    input  logic          addr_lsb,
    input  logic [AW-1:0] ptr,
    input  logic [7:0]    ram_rdata,
    input  logic [7:0]    stat_i,
    output logic          ack_go,
    output logic          rd_on,
    output logic [7:0]    tx_byte,
    output logic          ptr_step,
    output logic          ram_we,
    output logic [AW-1:0] ram_waddr,
    output logic [7:0]    ram_wdata,
    output logic          cmd_valid,
    output logic [7:0]    cmd_byte
);
    pstate_t state;
    logic    dc_q;
    logic    is_payload;
    logic    addr_hit;

    assign addr_hit   = (rx_byte[7:1] == {ADDR_HI, addr_lsb});
    assign is_payload = (state == PS_PAIR) || (state == PS_STREAM);

    // Pointer advances on a RAM write or on each RAM byte handed to the link.
    assign ptr_step = (byte_rdy && !start_det && !stop_det && is_payload && dc_q)
                    || (tx_load && dc_q);

    // Read bytes follow the last latched data/command selection.
    assign tx_byte = dc_q ? ram_rdata : stat_i;

    // Frame state, acknowledge decision and payload strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= PS_IDLE;
            dc_q      <= 1'b0;
            ack_go    <= 1'b0;
            rd_on     <= 1'b0;
            ram_we    <= 1'b0;
            ram_waddr <= '0;
            ram_wdata <= '0;
            cmd_valid <= 1'b0;
            cmd_byte  <= '0;
        end else begin
            ram_we    <= 1'b0;
            cmd_valid <= 1'b0;
            if (start_det) begin
                state <= PS_ADDR;
                rd_on <= 1'b0;
            end else if (stop_det) begin
                state <= PS_IDLE;
                rd_on <= 1'b0;
            end else if (byte_rdy) begin
                unique case (state)
                    PS_ADDR: begin
                        ack_go <= addr_hit;
                        if (!addr_hit) begin
                            state <= PS_IDLE;
                        end else if (rx_byte[0]) begin
                            state <= PS_READ;
                            rd_on <= 1'b1;
                        end else begin
                            state <= PS_CTRL;
                        end
                    end
                    PS_CTRL: begin
                        ack_go <= 1'b1;
                        dc_q   <= rx_byte[DC_BIT];
                        state  <= rx_byte[CO_BIT] ? PS_PAIR : PS_STREAM;
                    end
                    PS_PAIR, PS_STREAM: begin
                        ack_go <= 1'b1;
                        if (state == PS_PAIR) state <= PS_CTRL;
                        if (dc_q) begin
                            ram_we    <= 1'b1;
                            ram_waddr <= ptr;
                            ram_wdata <= rx_byte;
                        end else begin
                            cmd_valid <= 1'b1;
                            cmd_byte  <= rx_byte;
                        end
                    end
                    default: begin
                        ack_go <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cd_ptr.sv
// Display RAM data pointer with load and wrap-around increment.
// Assumes: load has priority over step in the same cycle.
module i2cd_ptr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] val,
    input  logic          step,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    // Load or advance the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (ld)   ptr <= val;
        else if (step) ptr <= ptr + ONE;
    end
endmodule

// File: rtl/panel_i2c_slave.sv
// Top: I2C slave front end for a display controller.
// Assumes: clk is fast enough that each SCL phase lasts more than
// SYNC_STAGES+2 cycles; RAM read data is combinational from ram_raddr.
module panel_i2c_slave #(
    parameter int         AW          = 10,
    parameter logic [5:0] ADDR_HI     = 6'b011110,
    parameter int         SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic          addr_lsb,
    input  logic          ptr_ld,
    input  logic [AW-1:0] ptr_val,
    input  logic [7:0]    stat_i,
    input  logic [7:0]    ram_rdata,
    output logic [AW-1:0] ram_raddr,
    output logic          ram_we,
    output logic [AW-1:0] ram_waddr,
    output logic [7:0]    ram_wdata,
    output logic          cmd_valid,
    output logic [7:0]    cmd_byte
);
    logic       scl_rise, scl_fall, start_det, stop_det, sda_s;
    logic       byte_rdy, tx_load, ack_go, rd_on, ptr_step;
    logic [7:0] rx_byte, tx_byte;

    i2cd_line_mon #(.STAGES(SYNC_STAGES)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_s     (sda_s)
    );

    i2cd_link u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_s     (sda_s),
        .ack_go    (ack_go),
        .rd_on     (rd_on),
        .tx_byte   (tx_byte),
        .byte_rdy  (byte_rdy),
        .rx_byte   (rx_byte),
        .tx_load   (tx_load),
        .sda_oe    (sda_oe)
    );

    i2cd_frame #(.AW(AW), .ADDR_HI(ADDR_HI)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_det (start_det),
        .stop_det  (stop_det),
        .byte_rdy  (byte_rdy),
        .rx_byte   (rx_byte),
        .tx_load   (tx_load),
        .addr_lsb  (addr_lsb),
        .ptr       (ram_raddr),
        .ram_rdata (ram_rdata),
        .stat_i    (stat_i),
        .ack_go    (ack_go),
        .rd_on     (rd_on),
        .tx_byte   (tx_byte),
        .ptr_step  (ptr_step),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte)
    );

    i2cd_ptr #(.AW(AW)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ptr_ld),
        .val   (ptr_val),
        .step  (ptr_step),
        .ptr   (ram_raddr)
    );
endmodule

// File: rtl/panel_i2c_slave_chk.sv
// Protocol checker bound to the top; observes ports only.
// Assumes: SCL phases are longer than the synchroniser delay.
module panel_i2c_slave_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_oe,
    input logic          ptr_ld,
    input logic [AW-1:0] ram_raddr,
    input logic          ram_we,
    input logic [AW-1:0] ram_waddr,
    input logic          cmd_valid
);
    logic [AW-1:0] waddr_next;
    assign waddr_next = ram_waddr + {{(AW-1){1'b0}}, 1'b1};

    // R8: drive on SDA only changes while SCL is low
    assert_drive_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    // R7: command and RAM strobes never coincide
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && cmd_valid));

    // R7: a command strobe lasts one cycle
    assert_cmd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R6: a RAM write strobe lasts one cycle
    assert_we_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

    // R6: pointer is one past the written address unless just loaded (R13)
    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !$past(ptr_ld)) |-> (ram_raddr == waddr_next));
endmodule

bind panel_i2c_slave panel_i2c_slave_chk #(.AW(AW)) u_chk (.*);

// File: tb/panel_i2c_slave_tb_top.sv
module panel_i2c_slave_tb_top;
    localparam int AW = 4;
    localparam int HP = 16;
    localparam int IW = AW + 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl = 1'b1;
    logic          sda_m = 1'b1;
    logic          sda_bus;
    logic          sda_oe;
    logic          ptr_ld = 1'b0;
    logic [AW-1:0] ptr_val = '0;
    logic [7:0]    stat_i = 8'hA5;
    logic [7:0]    ram_rdata;
    logic [AW-1:0] ram_raddr;
    logic          ram_we;
    logic [AW-1:0] ram_waddr;
    logic [7:0]    ram_wdata;
    logic          cmd_valid;
    logic [7:0]    cmd_byte;
    logic [7:0]    mem [16];

    int n_cmp = 0, n_bad = 0, mon_cmp = 0, mon_bad = 0;
    logic [IW-1:0] expq [$];
    string         tagq [$];

    always #2 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign ram_rdata = mem[ram_raddr];

    always_ff @(posedge clk) if (ram_we) mem[ram_waddr] <= ram_wdata;

    panel_i2c_slave #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .addr_lsb(1'b1), .ptr_ld(ptr_ld), .ptr_val(ptr_val), .stat_i(stat_i),
        .ram_rdata(ram_rdata), .ram_raddr(ram_raddr), .ram_we(ram_we),
        .ram_waddr(ram_waddr), .ram_wdata(ram_wdata), .cmd_valid(cmd_valid),
        .cmd_byte(cmd_byte)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic exp_ram(input logic [AW-1:0] a, input logic [7:0] d, input string t);
        expq.push_back({1'b1, a, d});
        tagq.push_back(t);
    endtask

    task automatic exp_cmd(input logic [7:0] d, input string t);
        expq.push_back({1'b0, {AW{1'b0}}, d});
        tagq.push_back(t);
    endtask

    // Scoreboard monitor: pop one expected item per strobe.
    always @(negedge clk) begin
        if (rst_n && (ram_we || cmd_valid)) begin
            logic [IW-1:0] got;
            got = ram_we ? {1'b1, ram_waddr, ram_wdata} : {1'b0, {AW{1'b0}}, cmd_byte};
            mon_cmp++;
            if (expq.size() == 0) begin
                mon_bad++;
                $display("FAIL R3 unexpected strobe: actual %0h expected none", got);
            end else begin
                logic [IW-1:0] e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                if (got != e) begin
                    mon_bad++;
                    $display("FAIL %s strobe: actual %0h expected %0h", t, got, e);
                end
            end
        end
    end

    task automatic hp();
        repeat (HP) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; hp(); scl = 1'b1; hp(); sda_m = 1'b0; hp(); scl = 1'b0; hp();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; hp(); scl = 1'b1; hp(); sda_m = 1'b1; hp();
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hp(); scl = 1'b1; hp(); scl = 1'b0; hp();
        end
        sda_m = 1'b1; hp(); scl = 1'b1;
        repeat (HP/2) @(negedge clk);
        ack = ~sda_bus;
        repeat (HP/2) @(negedge clk);
        scl = 1'b0; hp();
    endtask

    task automatic rd_byte(output logic [7:0] b, input bit mack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hp(); scl = 1'b1;
            repeat (HP/2) @(negedge clk);
            b[i] = sda_bus;
            repeat (HP/2) @(negedge clk);
            scl = 1'b0;
        end
        hp(); sda_m = ~mack; hp(); scl = 1'b1; hp(); scl = 1'b0; hp(); sda_m = 1'b1;
    endtask

    task automatic load_ptr(input logic [AW-1:0] v);
        @(negedge clk); ptr_ld = 1'b1; ptr_val = v;
        @(negedge clk); ptr_ld = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 n_cmp + mon_cmp, n_bad + mon_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        bit ack;
        logic [7:0] rb;
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        // R1: state during reset
        check(sda_oe == 1'b0 && ram_we == 1'b0 && cmd_valid == 1'b0, "R1", "outputs in reset",
              {sda_oe, ram_we, cmd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ram_raddr == '0 && sda_oe == 1'b0, "R1", "pointer after reset", ram_raddr, 0);

        // R2 R4 R7 R8: paired command words, then a data pair
        i2c_start();
        wr_byte(8'h7A, ack); check(ack, "R2", "address ack", ack, 1);
        wr_byte(8'h80, ack); check(ack, "R8", "control ack", ack, 1);
        exp_cmd(8'hAE, "R7");
        wr_byte(8'hAE, ack); check(ack, "R8", "payload ack", ack, 1);
        wr_byte(8'h80, ack); check(ack, "R4", "second control ack", ack, 1);
        exp_cmd(8'h11, "R4");
        wr_byte(8'h11, ack);
        wr_byte(8'hC0, ack); check(ack, "R4", "control after pair", ack, 1);
        exp_ram(4'd0, 8'h55, "R6");
        wr_byte(8'h55, ack);
        i2c_stop();
        check(ram_raddr == 4'd1, "R6", "pointer after write", ram_raddr, 1);

        // R5 R14: Co=0 D/C=1 with noise in bits 5..0, then control-looking payload
        i2c_start();
        wr_byte(8'h7A, ack);
        wr_byte(8'h7F, ack); check(ack, "R14", "control with low bits set", ack, 1);
        exp_ram(4'd1, 8'h80, "R5");
        wr_byte(8'h80, ack);
        exp_ram(4'd2, 8'hC0, "R5");
        wr_byte(8'hC0, ack);
        exp_ram(4'd3, 8'h00, "R5");
        wr_byte(8'h00, ack); check(ack, "R5", "stream ack", ack, 1);
        i2c_stop();
        check(ram_raddr == 4'd4, "R6", "pointer after stream", ram_raddr, 4);

        // R3: mismatched address ignored
        i2c_start();
        wr_byte(8'h78, ack); check(!ack, "R3", "no ack on mismatch", ack, 0);
        wr_byte(8'h00, ack); check(!ack, "R3", "no ack after mismatch", ack, 0);
        wr_byte(8'h12, ack); check(!ack, "R3", "no ack on later byte", ack, 0);
        i2c_stop();
        check(ram_raddr == 4'd4, "R3", "pointer untouched", ram_raddr, 4);

        // R12: repeated START after mismatch restarts matching
        i2c_start();
        wr_byte(8'h78, ack);
        wr_byte(8'h33, ack);
        i2c_start();
        wr_byte(8'h7A, ack); check(ack, "R12", "ack after repeated start", ack, 1);
        wr_byte(8'h00, ack);
        exp_cmd(8'h21, "R7");
        wr_byte(8'h21, ack);
        exp_cmd(8'h22, "R7");
        wr_byte(8'h22, ack);
        i2c_stop();

        // R13 R6: pointer load and wrap
        load_ptr(4'd14);
        check(ram_raddr == 4'd14, "R13", "pointer load", ram_raddr, 14);
        i2c_start();
        wr_byte(8'h7A, ack);
        wr_byte(8'h40, ack);
        exp_ram(4'd14, 8'hE1, "R6"); wr_byte(8'hE1, ack);
        exp_ram(4'd15, 8'hE2, "R6"); wr_byte(8'hE2, ack);
        exp_ram(4'd0,  8'hE3, "R6"); wr_byte(8'hE3, ack);
        i2c_stop();
        check(ram_raddr == 4'd1, "R6", "pointer wrap", ram_raddr, 1);

        // R10 R11: RAM read, master NACK ends sending
        load_ptr(4'd1);
        i2c_start();
        wr_byte(8'h7B, ack); check(ack, "R10", "read address ack", ack, 1);
        rd_byte(rb, 1'b1); check(rb == 8'h80, "R10", "ram read byte 0", rb, 8'h80);
        rd_byte(rb, 1'b0); check(rb == 8'hC0, "R10", "ram read byte 1", rb, 8'hC0);
        rd_byte(rb, 1'b0); check(rb == 8'hFF, "R11", "bus released after nack", rb, 8'hFF);
        i2c_stop();
        check(ram_raddr == 4'd3, "R10", "pointer after reads", ram_raddr, 3);

        // R9: STOP resets pairing; 0x80 is control, not data
        i2c_start();
        wr_byte(8'h7A, ack);
        wr_byte(8'h80, ack);
        exp_cmd(8'h3C, "R9");
        wr_byte(8'h3C, ack);
        i2c_stop();

        // R10: status read after command-mode write
        i2c_start();
        wr_byte(8'h7B, ack);
        rd_byte(rb, 1'b0); check(rb == 8'hA5, "R10", "status read", rb, 8'hA5);
        i2c_stop();
        check(ram_raddr == 4'd3, "R10", "pointer fixed on status read", ram_raddr, 3);

        repeat (20) @(negedge clk);
        check(expq.size() == 0, "R4", "all expected strobes seen", expq.size(), 0);
        finish_run();
    end
endmodule